// File: doc/BRIEF.md
# Line-Granular Read-Modify-Write Engine

This block connects a narrow processor-side port to a memory that only moves whole 128-bit lines. The processor issues byte, halfword or 32-bit word reads and writes with a byte address. The memory side sees only a line address, which is the byte address with the four offset bits dropped, plus a full-width data bus and a request/ready handshake. Read data comes back on a separate valid strobe.

A read fetches the line that holds the addressed bytes and returns them on a 32-bit response bus. A write narrower than a line fetches that line first and replaces only the addressed byte lanes. It then writes the whole line back. One request is in flight at a time. The processor port stays busy until a one-cycle done pulse, and misaligned requests are rejected without any memory traffic.

Top module: `line_rmw_engine`

## Requirements
- R1: Every memory request carries `mem_line_addr` equal to bits [ADDR_W-1:4] of the accepted byte address. The low four address bits never reach the memory.
- R2: An accepted aligned read makes exactly one line read and no line write. At the done pulse, `rsp_rdata` holds the addressed bytes right-aligned and zero-extended. The lowest-addressed byte goes in bits [7:0].
- R3: An accepted aligned write first makes one line read and then exactly one line write to the same line address. In the written line the addressed lanes hold the write data, with byte i of `req_wdata` going to lane offset+i, and every other lane keeps its fetched value.
- R4: `req_size` encodes 0 = byte, 1 = halfword, 2 = word and 3 = invalid. An access touches 1, 2 or 4 consecutive byte lanes starting at lane `req_addr[3:0]`, where lane k is bits [8k+7:8k] of the line.
- R5: A request is rejected when its size is 3, when it is a halfword at an odd address, or when it is a word at an address that is not a multiple of 4. A rejected request raises `rsp_err` together with the done pulse on the cycle after acceptance, makes no memory request, and changes no memory contents.
- R6: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the done cycle. `rsp_done` lasts exactly one cycle. A request presented while busy is ignored.
- R7: Once `mem_req` rises, it stays high with a stable address, write flag and write data until a cycle in which `mem_ready` is high.
- R8: While reset is held and right after it, `busy`, `rsp_done`, `rsp_err` and `mem_req` are low.
- R9: Read data arrives on `mem_rvalid` in a cycle after the read request has been accepted. The engine waits any number of cycles for it and for `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R4) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Rejected request, valid with rsp_done |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a line write |
| mem_line_addr | output | ADDR_W-4 | Line address |
| mem_wdata | output | 128 | Line write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Line read data valid |
| mem_rdata | input | 128 | Line read data |

## Verification
Directed cases place each access size at the first and last legal lane of a line. These cases show whether lane selection and the zero-extension of reads depend on the offset correctly. Writes to every lane position, checked later by read-back and by a full comparison of the memory image, show whether neighbouring lanes survive the merge. Misaligned and invalid sizes are mixed with legal traffic to show that rejection suppresses all memory cycles. A request poked during a busy transaction shows that the port ignores it. Random traffic with random memory stall and latency shows whether the handshake waits hold up under arbitrary timing.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_MERGE,
    ST_WR_REQ,
    ST_DONE
  } eng_state_e;

  // number of byte lanes an access touches; 0 for the invalid code
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rmw_lane_decode.sv
module rmw_lane_decode #(
  parameter int LANES = 16,
  parameter int OFF_W = 4
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] offset,
  output logic [LANES-1:0] lane_en,
  output logic             misaligned
);
  import rmw_pkg::*;

  function automatic logic is_misaligned(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return off[0];
      2'd2:    return |off[1:0];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lanes_of(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    logic [LANES-1:0] m;
    int unsigned n;
    n = size_bytes(sz);
    m = '0;
    for (int i = 0; i < LANES; i++)
      m[i] = (i >= int'(off)) && (i < int'(off) + int'(n));
    return m;
  endfunction

  always_comb begin
    misaligned = is_misaligned(size, offset);
    lane_en    = misaligned ? '0 : lanes_of(size, offset);
  end

endmodule

// File: rtl/rmw_line_merge.sv
module rmw_line_merge #(
  parameter int LANES      = 16,
  parameter int WORD_BYTES = 4,
  localparam int WB_W      = $clog2(WORD_BYTES)
) (
  input  logic [LANES*8-1:0]      old_line,
  input  logic [LANES-1:0]        lane_en,
  input  logic [WB_W-1:0]         off_lo,
  input  logic [WORD_BYTES*8-1:0] wdata,
  output logic [LANES*8-1:0]      new_line
);

  // lane i takes write byte (i - offset) mod WORD_BYTES when enabled
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [WB_W-1:0] src;
      assign src = WB_W'(i) - off_lo;
      assign new_line[i*8 +: 8] = lane_en[i] ? wdata[src*8 +: 8] : old_line[i*8 +: 8];
    end
  endgenerate

endmodule

// File: rtl/rmw_lane_extract.sv
module rmw_lane_extract #(
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] rdata
);
  import rmw_pkg::*;

  localparam int WORD_BYTES = WORD_W / 8;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                             input logic [OFF_W-1:0] off,
                                             input logic [1:0] sz);
    logic [LINE_W-1:0] sh;
    logic [WORD_W-1:0] r;
    int unsigned n;
    sh = ln >> {off, 3'b000};
    n  = size_bytes(sz);
    r  = '0;
    for (int b = 0; b < WORD_BYTES; b++)
      if (b < int'(n)) r[b*8 +: 8] = sh[b*8 +: 8];
    return r;
  endfunction

  assign rdata = pick(line, offset, size);

endmodule

// File: rtl/line_rmw_engine.sv
module line_rmw_engine #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  localparam int LANES      = LINE_W / 8,
  localparam int OFF_W      = $clog2(LANES),
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int WB_W       = $clog2(WORD_BYTES),
  localparam int LADDR_W    = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               busy,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_line_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [LINE_W-1:0]  mem_rdata
);
  import rmw_pkg::*;

  eng_state_e          state;
  logic [ADDR_W-1:0]   addr_q;
  logic [1:0]          size_q;
  logic                we_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [LINE_W-1:0]   line_q;
  logic [WORD_W-1:0]   rdata_q;
  logic                err_q;
  logic                line_fetched;

  // named events for the assertions
  logic                accept;
  logic                accept_bad;
  logic                line_arrives;
  logic                req_stalled;

  logic [LANES-1:0]    acc_lanes;
  logic                acc_misaligned;
  logic [LANES-1:0]    held_lanes;
  logic                held_misaligned;
  logic [LINE_W-1:0]   merged_line;
  logic [WORD_W-1:0]   picked;

  // decode at the port to reject before any memory cycle
  rmw_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_dec_in (
    .size(req_size), .offset(req_addr[OFF_W-1:0]),
    .lane_en(acc_lanes), .misaligned(acc_misaligned)
  );

  // decode of the held request drives the merge
  rmw_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_dec_held (
    .size(size_q), .offset(addr_q[OFF_W-1:0]),
    .lane_en(held_lanes), .misaligned(held_misaligned)
  );

  rmw_line_merge #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_merge (
    .old_line(line_q), .lane_en(held_lanes), .off_lo(addr_q[WB_W-1:0]),
    .wdata(wdata_q), .new_line(merged_line)
  );

  rmw_lane_extract #(.LINE_W(LINE_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_extract (
    .line(mem_rdata), .offset(addr_q[OFF_W-1:0]), .size(size_q), .rdata(picked)
  );

  assign accept       = (state == ST_IDLE) && req_valid;
  assign accept_bad   = accept && acc_misaligned;
  assign line_arrives = (state == ST_RD_WAIT) && mem_rvalid;
  assign req_stalled  = mem_req && !mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      addr_q       <= '0;
      size_q       <= '0;
      we_q         <= 1'b0;
      wdata_q      <= '0;
      line_q       <= '0;
      rdata_q      <= '0;
      err_q        <= 1'b0;
      line_fetched <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q       <= req_addr;
            size_q       <= req_size;
            we_q         <= req_write;
            wdata_q      <= req_wdata;
            rdata_q      <= '0;
            line_fetched <= 1'b0;
            err_q        <= acc_misaligned;
            state        <= acc_misaligned ? ST_DONE : ST_RD_REQ;
          end
        end
        ST_RD_REQ:  if (mem_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rvalid) begin
            line_q       <= mem_rdata;
            line_fetched <= 1'b1;
            if (!we_q) rdata_q <= picked;
            state        <= we_q ? ST_MERGE : ST_DONE;
          end
        end
        ST_MERGE: begin
          line_q <= merged_line;
          state  <= ST_WR_REQ;
        end
        ST_WR_REQ:  if (mem_ready) state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign rsp_done      = (state == ST_DONE);
  assign rsp_err       = rsp_done && err_q;
  assign rsp_rdata     = rdata_q;
  assign mem_req       = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_we        = (state == ST_WR_REQ);
  assign mem_line_addr = addr_q[ADDR_W-1:OFF_W];
  assign mem_wdata     = line_q;

  // R7: a stalled request holds its address, direction and data
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_stalled |=> mem_req && $stable(mem_line_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6: done lasts one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R6: an accepted request makes the port busy next cycle
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R5: rejection completes at once with the error flag and no memory request
  assert_reject_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> rsp_done && rsp_err && !mem_req);

  // R4: a legal access enables between one and four lanes
  assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !acc_misaligned) |-> ($countones(acc_lanes) >= 1 && $countones(acc_lanes) <= WORD_BYTES));

  // R3: a line write only follows a completed fetch of a legal request
  assert_write_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (line_fetched && !held_misaligned));

  // R9: line data is only taken while waiting for it
  assert_data_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_arrives |=> line_fetched);

endmodule

// File: tb/line_rmw_engine_test.sv
module line_rmw_engine_test;

  localparam int ADDR_W  = 12;
  localparam int LINE_W  = 128;
  localparam int WORD_W  = 32;
  localparam int LADDR_W = ADDR_W - 4;
  localparam int NLINES  = 1 << LADDR_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_write = 1'b0;
  logic [1:0]         req_size = 2'd0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [WORD_W-1:0]  req_wdata = '0;
  logic               busy, rsp_done, rsp_err;
  logic [WORD_W-1:0]  rsp_rdata;
  logic               mem_req, mem_we;
  logic [LADDR_W-1:0] mem_line_addr;
  logic [LINE_W-1:0]  mem_wdata;
  logic               mem_ready = 1'b0;
  logic               mem_rvalid = 1'b0;
  logic [LINE_W-1:0]  mem_rdata = '0;

  always #5 clk = ~clk;

  line_rmw_engine #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line_addr(mem_line_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model and reference image
  logic [LINE_W-1:0]  mem_img [NLINES];
  logic [LINE_W-1:0]  ref_img [NLINES];
  int unsigned        n_rd = 0, n_wr = 0;
  logic [LADDR_W-1:0] last_rd_addr = '0, last_wr_addr = '0;
  logic               pend = 1'b0;
  logic [LADDR_W-1:0] pend_addr = '0;
  int unsigned        pend_cnt = 0;
  bit                 stall_on = 1'b1;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_img[pend_addr];
        pend       <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem_img[mem_line_addr] <= mem_wdata;
        n_wr         <= n_wr + 1;
        last_wr_addr <= mem_line_addr;
      end else begin
        pend         <= 1'b1;
        pend_addr    <= mem_line_addr;
        pend_cnt     <= stall_on ? $urandom % 3 : 0;
        n_rd         <= n_rd + 1;
        last_rd_addr <= mem_line_addr;
      end
    end
    mem_ready <= stall_on ? (($urandom % 4) != 0) : 1'b1;
  end

  int unsigned n_checks = 0, n_fail = 0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [1:0] sz, input logic [ADDR_W-1:0] a);
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd1) return a[0];
    if (sz == 2'd2) return a[1:0] != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [LINE_W-1:0] ln, input logic [3:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, ln[off*8 +: 8]};
      2'd1:    return {16'h0, ln[off*8 +: 16]};
      default: return ln[off*8 +: 32];
    endcase
  endfunction

  function automatic logic [LINE_W-1:0] exp_write(input logic [LINE_W-1:0] ln, input logic [3:0] off,
                                                  input logic [1:0] sz, input logic [31:0] wd);
    logic [LINE_W-1:0] r;
    int nb;
    r  = ln;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < nb; i++) r[(int'(off) + i)*8 +: 8] = wd[i*8 +: 8];
    return r;
  endfunction

  task automatic run_req(input bit wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                         input logic [31:0] wd, input bit poke);
    bit                 bad;
    logic [LADDR_W-1:0] ln;
    logic [31:0]        exp_rd;
    int unsigned        rd0, wr0, t;
    bad = is_bad(sz, a);
    ln  = a[ADDR_W-1:4];
    exp_rd = bad ? 32'h0 : exp_read(ref_img[ln], a[3:0], sz);
    if (wr && !bad) ref_img[ln] = exp_write(ref_img[ln], a[3:0], sz, wd);
    rd0 = n_rd;
    wr0 = n_wr;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
    if (poke && !bad) begin
      // R6: a write presented while busy must be ignored
      req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
      req_addr = a ^ 12'h040; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!rsp_done && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(rsp_done == 1'b1, "R6 done within timeout", rsp_done, 1);
    check(rsp_err == bad, "R5 error flag", rsp_err, bad);
    if (!wr && !bad) check(rsp_rdata == exp_rd, "R2 read data", rsp_rdata, exp_rd);
    check((n_rd - rd0) == (bad ? 0 : 1), bad ? "R5 no read on reject" : "R2 R3 one line read",
          n_rd - rd0, bad ? 0 : 1);
    check((n_wr - wr0) == ((wr && !bad) ? 1 : 0), bad ? "R5 no write on reject" : "R3 line write count",
          n_wr - wr0, (wr && !bad) ? 1 : 0);
    if (!bad) check(last_rd_addr == ln, "R1 read line address", last_rd_addr, ln);
    if (wr && !bad) check(last_wr_addr == ln, "R1 R3 write line address", last_wr_addr, ln);
    @(negedge clk);
    check(rsp_done == 1'b0 && busy == 1'b0, "R6 done single cycle, port free", {rsp_done, busy}, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NLINES; i++) begin
      mem_img[i] = {i[31:0] * 32'h9E37_79B1, ~i[31:0], i[31:0] ^ 32'h5A5A_C3C3, i[31:0] * 32'h0101_0101 + 32'h1357};
      ref_img[i] = mem_img[i];
    end
    repeat (5) @(negedge clk);
    // R8 reset state
    check(busy == 0 && rsp_done == 0 && rsp_err == 0 && mem_req == 0, "R8 reset outputs",
          {busy, rsp_done, rsp_err, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && rsp_done == 0 && mem_req == 0, "R8 after reset", {busy, rsp_done, mem_req}, 0);

    // directed, no stalls: lane boundaries (R4)
    stall_on = 1'b0;
    run_req(0, 2'd0, 12'h120, 0, 0);           // R4 byte lane 0
    run_req(0, 2'd0, 12'h12F, 0, 0);           // R4 byte lane 15
    run_req(0, 2'd1, 12'h12E, 0, 0);           // R4 half top lanes
    run_req(0, 2'd2, 12'h12C, 0, 0);           // R4 word top lanes
    run_req(1, 2'd0, 12'h205, 32'hFFFF_FFA5, 0); // R3 byte write, upper bits unused
    run_req(0, 2'd2, 12'h204, 0, 0);           // R3 read back neighbours
    run_req(1, 2'd2, 12'h300, 32'h1122_3344, 0);
    run_req(1, 2'd1, 12'h30E, 32'h0000_BEEF, 0);
    run_req(0, 2'd2, 12'h300, 0, 0);
    run_req(0, 2'd1, 12'h30E, 0, 0);
    // R5 rejections
    run_req(1, 2'd2, 12'h402, 32'hCAFE_F00D, 0);
    run_req(0, 2'd1, 12'h403, 0, 0);
    run_req(1, 2'd3, 12'h400, 32'h1, 0);
    run_req(0, 2'd2, 12'h400, 0, 0);           // R5 line untouched
    // R6 poke while busy, then stalls on (R7, R9)
    stall_on = 1'b1;
    run_req(1, 2'd0, 12'h510, 32'h77, 1);
    run_req(0, 2'd2, 12'h550, 0, 0);           // R6 poked address untouched
    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [1:0]        sz;
      logic [ADDR_W-1:0] a;
      sz = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      a  = ADDR_W'($urandom);
      if (($urandom % 5) != 0) begin
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz == 2'd2) a[1:0] = 2'b00;
      end
      run_req(1'($urandom), sz, a, $urandom, 1'($urandom % 8 == 0));
    end
    // R3 full image comparison
    begin
      int mism;
      mism = 0;
      for (int i = 0; i < NLINES; i++) if (mem_img[i] !== ref_img[i]) mism++;
      check(mism == 0, "R3 memory image matches", mism, 0);
    end
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 1, 0);
      summary();
      $finish;
    end
  end

endmodule